// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the pin-level timing of one external bus cycle for an 8-bit processor whose data bus doubles as the low half of the address. The core places a request (cycle kind, 16-bit address, write byte) and holds it; the sequencer walks through its T-states. It strobes the address latch enable while the low address byte sits on the shared bus, and keeps the high address byte, the two status bits and the memory/IO select steady for the whole cycle. It then opens a read or write window on the active-low strobes. Read data is captured at the close of that window and a one-clock completion pulse follows.

A slow device stretches the window by holding the ready input low, which adds wait states. A bus master wanting the bus raises the hold input. The cycle in flight runs to the end, the block acknowledges, and it then releases the strobes and the bus until hold falls.

Top module: `mux_bus_seq`

## Requirements
- R1: A request is taken only when the sequencer is idle, hold is low, no completion pulse is showing and `req_type` is a known code: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Codes 5 to 7 are ignored: no ALE and no completion pulse follow.
- R2: An opcode fetch runs T1, T2, T3, T4. Every other kind runs T1, T2, T3. `done` is high for exactly one clock, the clock after the last T-state, once per request.
- R3: `{s1,s0}` is 2'b11 for a fetch, 2'b10 for memory or I/O read and 2'b01 for memory or I/O write. `io_m` is 1 for I/O kinds and 0 for memory kinds. Both stay constant from T1 to the last T-state.
- R4: `ale` is high only in T1 and for a single clock. In T1 `ad_out` carries the low address byte with `ad_oe`=1, and `addr_hi` carries the high address byte through every T-state.
- R5: For read kinds `rd_n` is low from T2 through T3, including wait states, with `ad_oe`=0. For write kinds `wr_n` is low over the same window with `ad_out` = write byte and `ad_oe`=1. The two strobes are never low together.
- R6: In T4 of a fetch both strobes are high and `ad_oe` is 0.
- R7: `ready` is sampled at the end of T2 and of each wait state. Every low sample adds one wait state, during which the strobes stay asserted and `done` stays low.
- R8: For read kinds, `rd_data` takes the value on `ad_in` at the end of T3 and is valid with `done`.
- R9: For I/O kinds the port number `req_addr[7:0]` appears both on `ad_out` in T1 and on `addr_hi`.
- R10: Hold raised during a cycle lets that cycle finish. `hlda` rises on the clock after the completion pulse. While `hlda` is high, `ale`=0, both strobes are high, `ad_oe`=0, `ctl_oe`=0, and requests are not taken.
- R11: When hold falls, `hlda` falls on the next clock and a pending request starts T1 on the clock after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request, held until `done` |
| req_type | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| ale | output | 1 | Address latch strobe |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| io_m | output | 1 | 1 for I/O cycle, 0 for memory |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value driven on the shared bus |
| ad_in | input | 8 | Value seen on the shared bus |
| ad_oe | output | 1 | Shared bus drive enable |
| ctl_oe | output | 1 | Drive enable for address high byte, select and strobes |
| ready | input | 1 | Device ready, low requests wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant acknowledge |

## Verification
The hardest case is a hold request that arrives in the middle of a stretched cycle. The bench has to see the cycle run to its natural end, the grant come one clock after the completion pulse, and a waiting core request stay parked until hold is withdrawn. The directed hold scenario raises hold during T2 of a memory read that also has wait states. It then keeps a fetch request asserted through the granted interval, drops hold, and checks the exact clocks on which the grant falls and T1 reappears. Wait-state counts of zero, one and two are applied on different cycle kinds so that the ready sample point is exercised at both T2 and the wait state.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } tst_e;

  function automatic logic cyc_known(input logic [2:0] t);
    return t <= 3'd4;
  endfunction

  function automatic logic cyc_is_fetch(input logic [2:0] t);
    return t == CYC_FETCH;
  endfunction

  function automatic logic cyc_is_read(input logic [2:0] t);
    return (t == CYC_FETCH) || (t == CYC_MRD) || (t == CYC_IORD);
  endfunction

  function automatic logic cyc_is_write(input logic [2:0] t);
    return (t == CYC_MWR) || (t == CYC_IOWR);
  endfunction

  function automatic logic cyc_is_io(input logic [2:0] t);
    return (t == CYC_IORD) || (t == CYC_IOWR);
  endfunction

  // status pair as {s1, s0}
  function automatic logic [1:0] cyc_status(input logic [2:0] t);
    logic [1:0] code;
    case (t)
      CYC_FETCH:          code = 2'b11;
      CYC_MRD, CYC_IORD:  code = 2'b10;
      CYC_MWR, CYC_IOWR:  code = 2'b01;
      default:            code = 2'b00;
    endcase
    return code;
  endfunction

  function automatic logic in_strobe_window(input tst_e s);
    return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
  endfunction

endpackage

// File: rtl/bus_seq_req.sv
module bus_seq_req
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [2:0]        lat_type,
  output logic [ADDR_W-DATA_W-1:0] lat_hi,
  output logic [DATA_W-1:0] lat_lo,
  output logic [DATA_W-1:0] lat_wdata
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0] hi_sel;

  // I/O cycles carry the port number on both halves of the address
  always_comb begin
    if (cyc_is_io(req_type)) hi_sel = HI_W'(req_addr[DATA_W-1:0]);
    else                     hi_sel = req_addr[ADDR_W-1:DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_type  <= 3'd0;
      lat_hi    <= '0;
      lat_lo    <= '0;
      lat_wdata <= '0;
    end else if (take) begin
      lat_type  <= req_type;
      lat_hi    <= hi_sel;
      lat_lo    <= req_addr[DATA_W-1:0];
      lat_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_type,
  input  logic [2:0] lat_type,
  input  logic       ready,
  input  logic       hold,
  output tst_e       state,
  output logic       take,
  output logic       last_t,
  output logic       done
);
  tst_e state_nx;
  logic fetch_q;

  assign fetch_q = cyc_is_fetch(lat_type);
  assign take    = (state == ST_IDLE) && req_valid && cyc_known(req_type)
                   && !hold && !done;
  assign last_t  = ((state == ST_T3) && !fetch_q) || (state == ST_T4);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (hold)      state_nx = ST_HOLD;
        else if (take) state_nx = ST_T1;
      end
      ST_T1:   state_nx = ST_T2;
      ST_T2:   state_nx = ready ? ST_T3 : ST_TW;
      ST_TW:   state_nx = ready ? ST_T3 : ST_TW;
      ST_T3:   state_nx = fetch_q ? ST_T4 : ST_IDLE;
      ST_T4:   state_nx = ST_IDLE;
      ST_HOLD: state_nx = hold ? ST_HOLD : ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= last_t;
    end
  end
endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tst_e              state,
  input  logic [2:0]        lat_type,
  input  logic [ADDR_W-DATA_W-1:0] lat_hi,
  input  logic [DATA_W-1:0] lat_lo,
  input  logic [DATA_W-1:0] lat_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              s1,
  output logic              s0,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ctl_oe,
  output logic              hlda,
  output logic [DATA_W-1:0] rd_data
);
  logic in_cycle, win, rd_k, wr_k;
  logic [1:0] st_code;

  assign in_cycle = (state == ST_T1) || (state == ST_T2) || (state == ST_TW)
                    || (state == ST_T3) || (state == ST_T4);
  assign win      = in_strobe_window(state);
  assign rd_k     = cyc_is_read(lat_type);
  assign wr_k     = cyc_is_write(lat_type);
  assign st_code  = cyc_status(lat_type);

  always_comb begin
    ale     = (state == ST_T1);
    s1      = in_cycle & st_code[1];
    s0      = in_cycle & st_code[0];
    io_m    = in_cycle & cyc_is_io(lat_type);
    rd_n    = !(win && rd_k);
    wr_n    = !(win && wr_k);
    addr_hi = in_cycle ? lat_hi : '0;
    hlda    = (state == ST_HOLD);
    ctl_oe  = (state != ST_HOLD);
    if (state == ST_T1) begin
      ad_out = lat_lo;
      ad_oe  = 1'b1;
    end else if (win && wr_k) begin
      ad_out = lat_wdata;
      ad_oe  = 1'b1;
    end else begin
      ad_out = '0;
      ad_oe  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rd_data <= '0;
    else if ((state == ST_T3) && rd_k) rd_data <= ad_in;
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ale,
  output logic              s1,
  output logic              s0,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_oe,
  output logic              ctl_oe,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);
  localparam int HI_W = ADDR_W - DATA_W;

  tst_e            state;
  logic            take, last_t;
  logic [2:0]      lat_type;
  logic [HI_W-1:0] lat_hi;
  logic [DATA_W-1:0] lat_lo, lat_wdata;

  bus_seq_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .take(take), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .lat_type(lat_type),
    .lat_hi(lat_hi), .lat_lo(lat_lo), .lat_wdata(lat_wdata)
  );

  bus_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .lat_type(lat_type), .ready(ready), .hold(hold), .state(state),
    .take(take), .last_t(last_t), .done(done)
  );

  bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state), .lat_type(lat_type),
    .lat_hi(lat_hi), .lat_lo(lat_lo), .lat_wdata(lat_wdata), .ad_in(ad_in),
    .ale(ale), .s1(s1), .s0(s0), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ctl_oe(ctl_oe),
    .hlda(hlda), .rd_data(rd_data)
  );
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk
  import bus_seq_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input tst_e state,
  input logic last_t,
  input logic ale,
  input logic s1,
  input logic s0,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic ctl_oe,
  input logic done,
  input logic ready,
  input logic hold,
  input logic hlda
);
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);                                                  // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));                                             // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_t |=> done);                                               // R2
  AST_STATUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_T2, ST_TW, ST_T3, ST_T4}) |-> $stable({s1, s0})); // R3
  AST_T4_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T4) |-> (rd_n && wr_n && !ad_oe));                 // R6
  AST_WAIT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_T2) && !ready) |=> (state == ST_TW && !done));    // R7
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ale && rd_n && wr_n && !ad_oe && !ctl_oe));          // R10
  AST_HLDA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);                                     // R11
endmodule

bind mux_bus_seq bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .last_t(last_t), .ale(ale),
  .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .ctl_oe(ctl_oe), .done(done), .ready(ready), .hold(hold), .hlda(hlda)
);

// File: tb/mux_bus_seq_tb.sv
`timescale 1ns/1ps
module mux_bus_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_type = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic done, ale, s1, s0, io_m, rd_n, wr_n, ad_oe, ctl_oe, hlda;
  logic [7:0] rd_data, addr_hi, ad_out;
  logic [7:0] ad_in = 8'h0;
  logic ready = 1'b1;
  logic hold = 1'b0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mux_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .rd_data(rd_data), .ale(ale), .s1(s1), .s0(s0), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_in(ad_in), .ad_oe(ad_oe), .ctl_oe(ctl_oe), .ready(ready),
    .hold(hold), .hlda(hlda)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected status pair, restated from the requirement table
  function automatic int exp_stat(input int t);
    if (t == 0) return 3;
    if (t == 1 || t == 3) return 2;
    return 1;
  endfunction

  task automatic run_cycle(input int t, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] din,
                           input int nw, input bit hold_mid);
    bit is_io = (t == 3) || (t == 4);
    bit is_wr = (t == 2) || (t == 4);
    logic [7:0] hi = is_io ? a[7:0] : a[15:8];
    @(negedge clk);
    req_valid = 1; req_type = 3'(t); req_addr = a; req_wdata = wd;
    @(negedge clk);
    chk("R4 ale in T1", ale, 1);
    chk("R4 low addr in T1", ad_out, a[7:0]);
    chk("R4 oe in T1", ad_oe, 1);
    chk("R9/R4 addr_hi", addr_hi, hi);
    chk("R3 status", {s1, s0}, exp_stat(t));
    chk("R3 io_m", io_m, is_io);
    chk("R5 strobes idle in T1", {rd_n, wr_n}, 2'b11);
    for (int i = 0; i <= nw + 1; i++) begin
      @(negedge clk);
      chk("R5 rd_n window", rd_n, is_wr);
      chk("R5 wr_n window", wr_n, !is_wr);
      chk("R5 oe window", ad_oe, is_wr);
      if (is_wr) chk("R5 write byte", ad_out, wd);
      chk("R7 no done in window", done, 0);
      chk("R4 addr_hi held", addr_hi, hi);
      chk("R4 no ale", ale, 0);
      if (i == 0 && hold_mid) hold = 1;
      ready = (i >= nw);
      ad_in = din;
    end
    if (t == 0) begin
      @(negedge clk);
      chk("R6 T4 strobes", {rd_n, wr_n}, 2'b11);
      chk("R6 T4 oe", ad_oe, 0);
      chk("R3 T4 status", {s1, s0}, 3);
      chk("R2 no done in T4", done, 0);
    end
    @(negedge clk);
    chk("R2 done pulse", done, 1);
    if (!is_wr) chk("R8 read data", rd_data, din);
    req_valid = 0; ad_in = 8'h0; ready = 1;
    @(negedge clk);
    chk("R2 done single", done, 0);
    chk("R2 no restart", ale, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R2 reset done", done, 0);
    chk("R4 reset ale", ale, 0);
    chk("R5 reset strobes", {rd_n, wr_n}, 2'b11);
    chk("R10 reset hlda", hlda, 0);
    chk("R5 reset oe", ad_oe, 0);
  endtask

  task automatic t_bad_type;
    @(negedge clk);
    req_valid = 1; req_type = 3'd6; req_addr = 16'h1234;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 unknown code no ale", ale, 0);
      chk("R1 unknown code no done", done, 0);
    end
    req_valid = 0;
  endtask

  task automatic t_hold;
    run_cycle(1, 16'h4455, 8'h00, 8'h77, 1, 1);
    chk("R10 hlda after cycle", hlda, 1);
    chk("R10 ctl released", ctl_oe, 0);
    req_valid = 1; req_type = 3'd0; req_addr = 16'h0100;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 hold blocks request", ale, 0);
      chk("R10 hlda held", hlda, 1);
      chk("R10 strobes released", {rd_n, wr_n}, 2'b11);
    end
    hold = 0;
    @(negedge clk);
    chk("R11 hlda falls", hlda, 0);
    chk("R11 no T1 yet", ale, 0);
    @(negedge clk);
    chk("R11 pending starts", ale, 1);
    chk("R11 fetch status", {s1, s0}, 3);
    for (int i = 0; i < 10 && !done; i++) @(negedge clk);
    chk("R11 pending completes", done, 1);
    req_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    run_cycle(0, 16'hA1B2, 8'h00, 8'h3C, 0, 0);
    run_cycle(1, 16'hC200, 8'h00, 8'h5A, 2, 0);
    run_cycle(2, 16'h2C00, 8'hE7, 8'h00, 0, 0);
    run_cycle(2, 16'h8001, 8'h19, 8'h00, 1, 0);
    run_cycle(3, 16'hFF80, 8'h00, 8'h39, 1, 0);
    run_cycle(4, 16'h0042, 8'h96, 8'h00, 0, 0);
    t_bad_type();
    t_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule